// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block sits at the front of a memory access path and turns a 32-bit virtual address into a physical address. The three most significant address bits pick one of four segments. Two kernel windows are not mapped: the translator removes the segment bits, and the two windows differ only in whether the access may be cached. The user segment and the upper kernel segment are mapped through an external translation lookaside buffer (TLB). The translator presents the 20-bit virtual page number on a lookup port, receives a frame number and attribute bits back in the same cycle, and joins the frame number with the unchanged 12-bit page offset.

Each request takes one cycle and its result appears registered on the next cycle. The translator enforces privilege: user mode may not touch any kernel segment. It reports three faults: address error, TLB miss and invalid entry. On a miss it loads the faulting page number into a context register whose upper bits hold a page-table base written by software, so that the register then points at the entry the refill handler needs. A separate register keeps the full address of the last address error or miss.

Top module: `vaddr_xlate`

## Requirements
- R1: Address bits 31..29 choose the segment. Pattern 0xx is the user segment (mapped, cacheable). 100 is kernel window 0 (unmapped, cacheable). 101 is kernel window 1 (unmapped, uncacheable). 11x is kernel window 2 (mapped, cacheable).
- R2: For a mapped segment, `tlb_vpn` equals address bits 31..12 in the same cycle. On a valid hit, `rsp_paddr` is `{tlb_pfn, address bits 11..0}`.
- R3: For both unmapped windows, `rsp_paddr` is the address with bits 31..29 cleared. For example, 0x80030284 gives 0x00030284 and 0xB00FF00D gives 0x100FF00D.
- R4: A request with `req_user` high to any address with bit 31 set raises `rsp_addr_err`, forces `rsp_paddr` and `rsp_cached` to zero, and raises neither miss nor invalid.
- R5: A mapped request without privilege error whose lookup reports `tlb_hit` low raises `rsp_miss` and gives `rsp_paddr` zero.
- R6: A mapped request whose lookup hits but with `tlb_entry_valid` low raises `rsp_invalid` and gives `rsp_paddr` zero.
- R7: `rsp_cached` is high for error-free unmapped window 0 accesses and for valid mapped hits with `tlb_nocache` low. It is low in every other case.
- R8: A cycle with `ctx_wr_en` high loads `ctx_wr_base` into `ctx_q` bits 31..21. Bits 1..0 of `ctx_q` always read zero.
- R9: A miss writes address bits 30..12 into `ctx_q` bits 20..2 and leaves bits 31..21 unchanged. A base write in the same cycle also takes effect.
- R10: `badva_q` captures the full address on an address error or a miss. It holds its value on every other request and on idle cycles.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The response flags and `rsp_paddr` are zero when `rsp_valid` is low.
- R12: After reset, every output register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | Requester runs in user mode |
| tlb_vpn | output | 20 | Page number sent to the TLB lookup |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_entry_valid | input | 1 | Matching entry is marked valid |
| tlb_nocache | input | 1 | Matching entry forbids caching |
| tlb_pfn | input | 20 | Frame number of the matching entry |
| ctx_wr_en | input | 1 | Write page-table base field |
| ctx_wr_base | input | 11 | New page-table base |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_cached | output | 1 | Access may be cached |
| rsp_miss | output | 1 | TLB miss |
| rsp_invalid | output | 1 | Entry found but invalid |
| rsp_addr_err | output | 1 | Privilege address error |
| ctx_q | output | 32 | Context register |
| badva_q | output | 32 | Last faulting virtual address |

## Verification
The hardest case to reach from the ports is a miss in the same cycle as a software base write. Both must land in separate fields of the context register. The bench also needs a kernel-window access in user mode whose page would have missed, which must leave the context register untouched. The bench models the lookup as arithmetic on the page number, so every fourth page misses and other low page bits select invalid and non-cacheable entries. It then sweeps every segment code in both modes across sixteen pages. One base write is placed on a missing request, so all of these cases occur in a single back-to-back run.

// File: rtl/vxl_pkg.sv
package vxl_pkg;

    typedef enum logic [1:0] {
        SEG_USER = 2'd0,
        SEG_KWIN0 = 2'd1,
        SEG_KWIN1 = 2'd2,
        SEG_KWIN2 = 2'd3
    } seg_e;

    function automatic seg_e seg_of(input logic [2:0] top);
        if (!top[2])
            return SEG_USER;
        else if (top[1])
            return SEG_KWIN2;
        else if (top[0])
            return SEG_KWIN1;
        else
            return SEG_KWIN0;
    endfunction

endpackage

// File: rtl/vxl_seg_decode.sv
module vxl_seg_decode
    import vxl_pkg::*;
(
    input  logic [2:0] top_bits,
    input  logic       user_mode,
    output seg_e       seg,
    output logic       mapped,
    output logic       win_cacheable,
    output logic       priv_err
);
    always_comb begin
        seg           = seg_of(top_bits);
        mapped        = (seg == SEG_USER) || (seg == SEG_KWIN2);
        win_cacheable = (seg != SEG_KWIN1);
        priv_err      = user_mode && (seg != SEG_USER);
    end
endmodule

// File: rtl/vxl_frame_join.sv
module vxl_frame_join #(
    parameter int PFN_W  = 20,
    parameter int PAGE_W = 12
) (
    input  logic [PFN_W-1:0]        pfn,
    input  logic [PAGE_W-1:0]       offset,
    input  logic                    hit,
    input  logic                    entry_valid,
    input  logic                    nocache,
    output logic [PFN_W+PAGE_W-1:0] paddr,
    output logic                    miss,
    output logic                    invalid,
    output logic                    cacheable
);
    logic usable;

    always_comb begin
        usable    = hit && entry_valid;
        paddr     = usable ? {pfn, offset} : '0;
        miss      = !hit;
        invalid   = hit && !entry_valid;
        cacheable = usable && !nocache;
    end
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
    import vxl_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int BASE_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic                     req_user,
    output logic [VA_W-PAGE_W-1:0]   tlb_vpn,
    input  logic                     tlb_hit,
    input  logic                     tlb_entry_valid,
    input  logic                     tlb_nocache,
    input  logic [VA_W-PAGE_W-1:0]   tlb_pfn,
    input  logic                     ctx_wr_en,
    input  logic [BASE_W-1:0]        ctx_wr_base,
    output logic                     rsp_valid,
    output logic [VA_W-1:0]          rsp_paddr,
    output logic                     rsp_cached,
    output logic                     rsp_miss,
    output logic                     rsp_invalid,
    output logic                     rsp_addr_err,
    output logic [VA_W-1:0]          ctx_q,
    output logic [VA_W-1:0]          badva_q
);
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int SEG_W = 3;
    localparam int BAD_W = VA_W - 1 - PAGE_W;
    localparam int BAD_LO = 2;

    typedef struct packed {
        logic            vld;
        logic [VA_W-1:0] pa;
        logic            cch;
        logic            miss;
        logic            inv;
        logic            aerr;
        logic [VA_W-1:0] ctx;
        logic [VA_W-1:0] bva;
    } st_t;

    st_t st_d, st_q;

    seg_e            seg;
    logic            is_mapped;
    logic            win_cch;
    logic            priv_err;
    logic [VA_W-1:0] map_pa;
    logic            map_miss;
    logic            map_inv;
    logic            map_cch;

    vxl_seg_decode u_seg (
        .top_bits      (req_vaddr[VA_W-1 -: SEG_W]),
        .user_mode     (req_user),
        .seg           (seg),
        .mapped        (is_mapped),
        .win_cacheable (win_cch),
        .priv_err      (priv_err)
    );

    vxl_frame_join #(
        .PFN_W  (VPN_W),
        .PAGE_W (PAGE_W)
    ) u_join (
        .pfn         (tlb_pfn),
        .offset      (req_vaddr[PAGE_W-1:0]),
        .hit         (tlb_hit),
        .entry_valid (tlb_entry_valid),
        .nocache     (tlb_nocache),
        .paddr       (map_pa),
        .miss        (map_miss),
        .invalid     (map_inv),
        .cacheable   (map_cch)
    );

    assign tlb_vpn = req_vaddr[VA_W-1:PAGE_W];

    always_comb begin
        st_d      = st_q;
        st_d.vld  = req_valid;
        st_d.pa   = '0;
        st_d.cch  = 1'b0;
        st_d.miss = 1'b0;
        st_d.inv  = 1'b0;
        st_d.aerr = 1'b0;
        if (req_valid) begin
            if (priv_err) begin
                st_d.aerr = 1'b1;
                st_d.bva  = req_vaddr;
            end else if (!is_mapped) begin
                st_d.pa  = {{SEG_W{1'b0}}, req_vaddr[VA_W-SEG_W-1:0]};
                st_d.cch = win_cch;
            end else begin
                st_d.pa   = map_pa;
                st_d.miss = map_miss;
                st_d.inv  = map_inv;
                st_d.cch  = map_cch;
                if (map_miss) begin
                    st_d.ctx[BAD_W+BAD_LO-1:BAD_LO] = req_vaddr[VA_W-2:PAGE_W];
                    st_d.bva = req_vaddr;
                end
            end
        end
        if (ctx_wr_en)
            st_d.ctx[VA_W-1 -: BASE_W] = ctx_wr_base;
        st_d.ctx[BAD_LO-1:0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rsp_valid    = st_q.vld;
    assign rsp_paddr    = st_q.pa;
    assign rsp_cached   = st_q.cch;
    assign rsp_miss     = st_q.miss;
    assign rsp_invalid  = st_q.inv;
    assign rsp_addr_err = st_q.aerr;
    assign ctx_q        = st_q.ctx;
    assign badva_q      = st_q.bva;
endmodule

// File: rtl/vxl_checker.sv
module vxl_checker #(
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_user,
    input logic            tlb_hit,
    input logic            tlb_entry_valid,
    input logic            rsp_valid,
    input logic [VA_W-1:0] rsp_paddr,
    input logic            rsp_cached,
    input logic            rsp_miss,
    input logic            rsp_invalid,
    input logic            rsp_addr_err,
    input logic [VA_W-1:0] ctx_q
);
    logic kern, mapped_seg, no_err, win1;

    always_comb begin
        kern       = req_vaddr[VA_W-1];
        mapped_seg = !kern || req_vaddr[VA_W-2];
        no_err     = !(req_user && kern);
        win1       = req_vaddr[VA_W-1 -: 3] == 3'b101;
    end

    p_user_kernel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && kern) |=> (rsp_valid && rsp_addr_err && !rsp_miss && !rsp_invalid));

    p_window_strip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && no_err && !mapped_seg)
        |=> (rsp_paddr == {3'b000, $past(req_vaddr[VA_W-4:0])}));

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && no_err && mapped_seg && tlb_hit && tlb_entry_valid)
        |=> (rsp_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0])));

    p_miss_ctx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && no_err && mapped_seg && !tlb_hit)
        |=> (rsp_miss && ctx_q[VA_W-PAGE_W:2] == $past(req_vaddr[VA_W-2:PAGE_W])));

    p_win1_uncached_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win1) |=> !rsp_cached);

    p_single_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_miss, rsp_invalid, rsp_addr_err}) <= 1);

    p_resp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_miss && !rsp_invalid && !rsp_addr_err && rsp_paddr == '0));
endmodule

bind vaddr_xlate vxl_checker #(
    .VA_W   (VA_W),
    .PAGE_W (PAGE_W)
) u_vxl_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_vaddr       (req_vaddr),
    .req_user        (req_user),
    .tlb_hit         (tlb_hit),
    .tlb_entry_valid (tlb_entry_valid),
    .rsp_valid       (rsp_valid),
    .rsp_paddr       (rsp_paddr),
    .rsp_cached      (rsp_cached),
    .rsp_miss        (rsp_miss),
    .rsp_invalid     (rsp_invalid),
    .rsp_addr_err    (rsp_addr_err),
    .ctx_q           (ctx_q)
);

// File: tb/vaddr_xlate_test.sv
`timescale 1ns/1ps
module vaddr_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic [19:0] tlb_vpn;
    logic        tlb_hit, tlb_entry_valid, tlb_nocache;
    logic [19:0] tlb_pfn;
    logic        ctx_wr_en = 1'b0;
    logic [10:0] ctx_wr_base = '0;
    logic        rsp_valid, rsp_cached, rsp_miss, rsp_invalid, rsp_addr_err;
    logic [31:0] rsp_paddr, ctx_q, badva_q;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] exp_ctx = '0;
    logic [31:0] exp_bva = '0;

    always #2 clk = ~clk;

    // Arithmetic TLB model: miss when page bits 1..0 are 11, invalid when
    // bit 2 is set, non-cacheable when bit 3 is set, frame = page ^ 0x5A5A5.
    always_comb begin
        tlb_hit         = tlb_vpn[1:0] != 2'b11;
        tlb_entry_valid = !tlb_vpn[2];
        tlb_nocache     = tlb_vpn[3];
        tlb_pfn         = tlb_vpn ^ 20'h5A5A5;
    end

    vaddr_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_user(req_user), .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit),
        .tlb_entry_valid(tlb_entry_valid), .tlb_nocache(tlb_nocache),
        .tlb_pfn(tlb_pfn), .ctx_wr_en(ctx_wr_en), .ctx_wr_base(ctx_wr_base),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cached(rsp_cached),
        .rsp_miss(rsp_miss), .rsp_invalid(rsp_invalid), .rsp_addr_err(rsp_addr_err),
        .ctx_q(ctx_q), .badva_q(badva_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] va, e_pa;
        logic [19:0] vpn;
        logic [2:0]  sg;
        logic        e_c, e_m, e_i, e_a, hit, ok;

        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check("R12 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check("R12 paddr", rsp_paddr, 32'h0);
        check("R12 flags", {28'b0, rsp_cached, rsp_miss, rsp_invalid, rsp_addr_err}, 32'h0);
        check("R12 ctx", ctx_q, 32'h0);
        check("R12 badva", badva_q, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 base write with no request
        @(negedge clk);
        ctx_wr_en = 1'b1;
        ctx_wr_base = 11'h5B3;
        exp_ctx[31:21] = 11'h5B3;
        @(posedge clk);
        #1;
        check("R8 base write", ctx_q, exp_ctx);
        check("R11 idle no rsp", {31'b0, rsp_valid}, 32'h0);

        for (int s = 0; s < 8; s++) begin
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 16; k++) begin
                    va = {3'(s), 13'h0A3C, 4'(k), 12'(k * 12'h111 + s)};
                    @(negedge clk);
                    req_valid = 1'b1;
                    req_user = 1'(u);
                    req_vaddr = va;
                    ctx_wr_en = (s == 7 && u == 0 && k == 3);
                    ctx_wr_base = 11'h2C7;
                    #1;
                    check("R2 lookup page", {12'b0, tlb_vpn}, {12'b0, va[31:12]});

                    sg = va[31:29];
                    vpn = va[31:12];
                    hit = vpn[1:0] != 2'b11;
                    ok = !vpn[2];
                    e_pa = '0; e_c = 0; e_m = 0; e_i = 0; e_a = 0;
                    if (u == 1 && sg[2]) begin
                        e_a = 1;
                        exp_bva = va;
                    end else if (sg[2] && !sg[1]) begin
                        e_pa = {3'b000, va[28:0]};
                        e_c = (sg != 3'b101);
                    end else if (!hit) begin
                        e_m = 1;
                        exp_ctx[20:2] = va[30:12];
                        exp_bva = va;
                    end else if (!ok) begin
                        e_i = 1;
                    end else begin
                        e_pa = {vpn ^ 20'h5A5A5, va[11:0]};
                        e_c = !vpn[3];
                    end
                    if (ctx_wr_en) exp_ctx[31:21] = ctx_wr_base;

                    @(posedge clk);
                    #1;
                    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
                    check("R1 R2 R3 paddr", rsp_paddr, e_pa);
                    check("R4 addr_err", {31'b0, rsp_addr_err}, {31'b0, e_a});
                    check("R5 miss", {31'b0, rsp_miss}, {31'b0, e_m});
                    check("R6 invalid", {31'b0, rsp_invalid}, {31'b0, e_i});
                    check("R7 cached", {31'b0, rsp_cached}, {31'b0, e_c});
                    check("R9 ctx", ctx_q, exp_ctx);
                    check("R10 badva", badva_q, exp_bva);
                end
            end
        end

        @(negedge clk);
        req_valid = 1'b0;
        ctx_wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R11 idle valid", {31'b0, rsp_valid}, 32'h0);
        check("R11 idle flags", {28'b0, rsp_cached, rsp_miss, rsp_invalid, rsp_addr_err}, 32'h0);
        check("R10 idle badva hold", badva_q, exp_bva);
        check("R8 ctx low bits", {30'b0, ctx_q[1:0]}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule